// File: doc/BRIEF.md
# Triggered output sequencer with blocking

The block sits behind a discriminator and turns each accepted single-cycle trigger into a set of output pulses. All of them start in the same clock cycle: two independent short timing pulses, a blocking pulse of programmable width, and a slow logic pulse of programmable width whose polarity can be inverted. An indicator stretch of a few milliseconds also restarts on every accepted trigger, so it stays on while triggers keep coming.

Further triggers are held off for a dead time. The dead time is the blocking width, but never less than a fixed minimum. An optional external gate, sampled only in the trigger cycle, decides whether a trigger may start a new set. It never cuts short a set that is already running. All widths are given in physical units. They are clamped to their allowed range and converted to clock cycles through a clock-frequency parameter. The widths in force for a set are the ones present in its trigger cycle.

Top module: `trig_out_seq`

## Requirements
- R1: A trigger accepted at clock edge n sets every output active in the cycle that follows edge n: both timing pulses, the blocking pulse, the slow pulse and the indicator.
- R2: Each timing pulse stays high for ceil(5*CLK_MHZ/1000) cycles, with a minimum of 1. This is 1 cycle at 125 MHz.
- R3: The blocking pulse stays high for ceil(B*CLK_MHZ/1000) cycles, where B is blk_ns_i in nanoseconds clamped to the range 10..1000. Values below 10 act as 10 and values above 1000 act as 1000.
- R4: While the dead time of an accepted trigger runs, any trigger is ignored. A held trigger is accepted once every dead time.
- R5: The dead time in cycles is the larger of ceil(20*CLK_MHZ/1000) and the blocking width from R3. The next trigger can be accepted at edge n plus the dead time.
- R6: The slow pulse is active for ceil(S*CLK_MHZ/1000) cycles, where S is 10*slow_w_i nanoseconds clamped to the range 500..2500. An accepted trigger restarts the slow pulse.
- R7: slow_o equals the active state of the slow pulse when slow_inv_i is 0, and its complement when slow_inv_i is 1. The idle level is therefore 0 or 1 respectively.
- R8: With gated_i = 1, a trigger is accepted only if gate_i is 1 in the trigger cycle. If the gate falls later, the running set still completes.
- R9: With gated_i = 0, gate_i has no effect and every trigger outside the dead time is accepted.
- R10: The indicator is high for IND_US*CLK_MHZ cycles after the most recent accepted trigger.
- R11: While rst_ni is low, tim_o, blk_o and ind_o are 0, slow_o equals slow_inv_i, and triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Single-cycle trigger from the discriminator |
| gate_i | input | 1 | External gate level, 1 allows a trigger |
| gated_i | input | 1 | 1 selects gated mode, 0 selects ungated mode |
| blk_ns_i | input | BLK_NS_W | Blocking width in ns |
| slow_w_i | input | SLOW_W_W | Slow pulse width in units of 10 ns |
| slow_inv_i | input | 1 | 1 inverts the slow output |
| tim_o | output | N_TIM | Timing pulses |
| blk_o | output | 1 | Blocking pulse |
| slow_o | output | 1 | Slow pulse, after the polarity select |
| ind_o | output | 1 | Indicator stretch |

## Verification
The assertions assume that the width inputs are driven to defined values from time zero. They also assume that the clock is above 100 MHz, so that the minimum dead time spans at least three cycles. The bench initialises every input at declaration and keeps the default 125 MHz conversion. Inputs change only on the falling clock edge. Triggers are issued as single pulses, as held levels spanning several dead times, and inside running sets. The width inputs are also taken outside their clamp range.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  // ceiling of ns * mhz / 1000, in cycles
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  localparam int unsigned BLK_MIN_NS  = 10;
  localparam int unsigned BLK_MAX_NS  = 1000;
  localparam int unsigned DEAD_MIN_NS = 20;
  localparam int unsigned TIM_NS      = 5;
  localparam int unsigned SLOW_MIN_NS = 500;
  localparam int unsigned SLOW_MAX_NS = 2500;
  localparam int unsigned SLOW_UNIT_NS = 10;
endpackage

// File: rtl/seq_width_conv.sv
module seq_width_conv
  import trig_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned BLK_NS_W = 10,
  parameter int unsigned SLOW_W_W = 8,
  parameter int unsigned BLKC_W   = 7,
  parameter int unsigned SLWC_W   = 9
) (
  input  logic [BLK_NS_W-1:0] blk_ns_i,
  input  logic [SLOW_W_W-1:0] slow_w_i,
  output logic [BLKC_W-1:0]   blk_cyc_o,
  output logic [BLKC_W-1:0]   dead_cyc_o,
  output logic [SLWC_W-1:0]   slow_cyc_o
);
  localparam int unsigned DEAD_MIN_CYC = ns_to_cyc(DEAD_MIN_NS, CLK_MHZ);
  localparam int unsigned BLK_MIN_CYC  = ns_to_cyc(BLK_MIN_NS, CLK_MHZ);
  localparam int unsigned BLK_MAX_CYC  = ns_to_cyc(BLK_MAX_NS, CLK_MHZ);
  localparam int unsigned SLW_MIN_CYC  = ns_to_cyc(SLOW_MIN_NS, CLK_MHZ);
  localparam int unsigned SLW_MAX_CYC  = ns_to_cyc(SLOW_MAX_NS, CLK_MHZ);

  logic [31:0] blk_cl, slow_cl;

  always_comb begin
    blk_cl = 32'(blk_ns_i);
    if (blk_cl < BLK_MIN_NS) blk_cl = BLK_MIN_NS;
    if (blk_cl > BLK_MAX_NS) blk_cl = BLK_MAX_NS;
    slow_cl = 32'(slow_w_i) * SLOW_UNIT_NS;
    if (slow_cl < SLOW_MIN_NS) slow_cl = SLOW_MIN_NS;
    if (slow_cl > SLOW_MAX_NS) slow_cl = SLOW_MAX_NS;
  end

  always_comb begin
    blk_cyc_o  = BLKC_W'((blk_cl * CLK_MHZ + 32'd999) / 32'd1000);
    slow_cyc_o = SLWC_W'((slow_cl * CLK_MHZ + 32'd999) / 32'd1000);
    if (32'(blk_cyc_o) < DEAD_MIN_CYC) dead_cyc_o = BLKC_W'(DEAD_MIN_CYC);
    else                               dead_cyc_o = blk_cyc_o;
  end

  always_comb begin
    AST_BLK_RANGE: assert (32'(blk_cyc_o) >= BLK_MIN_CYC && 32'(blk_cyc_o) <= BLK_MAX_CYC); // R3
    AST_DEAD_FLOOR: assert (dead_cyc_o >= blk_cyc_o && 32'(dead_cyc_o) >= DEAD_MIN_CYC); // R5
    AST_SLOW_RANGE: assert (32'(slow_cyc_o) >= SLW_MIN_CYC && 32'(slow_cyc_o) <= SLW_MAX_CYC); // R6
  end
endmodule

// File: rtl/seq_pulse.sv
module seq_pulse #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          out_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign out_o = (cnt_q != '0);

  AST_PULSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (len_i != '0) |=> out_o); // R1
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o && !load_i && (cnt_q == CW'(1)) |=> !out_o); // R3
endmodule

// File: rtl/trig_out_seq.sv
module trig_out_seq
  import trig_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned IND_US   = 3000,
  parameter int unsigned BLK_NS_W = 10,
  parameter int unsigned SLOW_W_W = 8,
  parameter int unsigned N_TIM    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trig_i,
  input  logic                gate_i,
  input  logic                gated_i,
  input  logic [BLK_NS_W-1:0] blk_ns_i,
  input  logic [SLOW_W_W-1:0] slow_w_i,
  input  logic                slow_inv_i,
  output logic [N_TIM-1:0]    tim_o,
  output logic                blk_o,
  output logic                slow_o,
  output logic                ind_o
);
  localparam int unsigned TIM_RAW  = ns_to_cyc(TIM_NS, CLK_MHZ);
  localparam int unsigned TIM_CYC  = (TIM_RAW < 1) ? 1 : TIM_RAW;
  localparam int unsigned TIMC_W   = $clog2(TIM_CYC + 1);
  localparam int unsigned BLKC_W   = $clog2(ns_to_cyc(BLK_MAX_NS, CLK_MHZ) + 1);
  localparam int unsigned SLWC_W   = $clog2(ns_to_cyc(SLOW_MAX_NS, CLK_MHZ) + 1);
  localparam int unsigned IND_CYC  = IND_US * CLK_MHZ;
  localparam int unsigned INDC_W   = $clog2(IND_CYC + 1);
  localparam int unsigned DEAD_MIN_CYC = ns_to_cyc(DEAD_MIN_NS, CLK_MHZ);

  logic [BLKC_W-1:0] blk_cyc, dead_cyc, dead_len;
  logic [SLWC_W-1:0] slow_cyc;
  logic busy, acc, slow_act;

  seq_width_conv #(
    .CLK_MHZ(CLK_MHZ), .BLK_NS_W(BLK_NS_W), .SLOW_W_W(SLOW_W_W),
    .BLKC_W(BLKC_W), .SLWC_W(SLWC_W)
  ) i_conv (
    .blk_ns_i(blk_ns_i), .slow_w_i(slow_w_i),
    .blk_cyc_o(blk_cyc), .dead_cyc_o(dead_cyc), .slow_cyc_o(slow_cyc)
  );

  // gate qualifies only the trigger cycle
  assign acc      = trig_i && !busy && (!gated_i || gate_i);
  // dead counter covers the cycles after the accept edge
  assign dead_len = dead_cyc - BLKC_W'(1);

  seq_pulse #(.CW(BLKC_W)) i_dead (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc), .len_i(dead_len), .out_o(busy));

  seq_pulse #(.CW(BLKC_W)) i_blk (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc), .len_i(blk_cyc), .out_o(blk_o));

  seq_pulse #(.CW(SLWC_W)) i_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc), .len_i(slow_cyc), .out_o(slow_act));

  seq_pulse #(.CW(INDC_W)) i_ind (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc), .len_i(INDC_W'(IND_CYC)), .out_o(ind_o));

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    seq_pulse #(.CW(TIMC_W)) i_tim (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc), .len_i(TIMC_W'(TIM_CYC)),
      .out_o(tim_o[g]));
  end

  assign slow_o = slow_act ^ slow_inv_i;

  AST_SET_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (&tim_o) && blk_o && ind_o && (slow_o != slow_inv_i)); // R1
  AST_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !acc); // R4
  AST_GATE_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_o) |-> $past(!gated_i || gate_i)); // R8

  if (DEAD_MIN_CYC >= 3) begin : g_dead_chk
    AST_DEAD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |=> ##1 !acc); // R5
  end
endmodule

// File: tb/test_trig_out_seq.sv
`timescale 1ns/1ps
module test_trig_out_seq;
  localparam int MHZ = 125;
  localparam int IND_US = 2;
  localparam int IND_C = IND_US * MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, gate = 1'b0, gated = 1'b0, inv = 1'b0;
  logic [9:0] blk_ns = 10'd100;
  logic [7:0] slw = 8'd50;
  logic [1:0] tim;
  logic blk, slow, ind;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R11";

  trig_out_seq #(.CLK_MHZ(MHZ), .IND_US(IND_US)) i_trig_out_seq (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .gate_i(gate), .gated_i(gated),
    .blk_ns_i(blk_ns), .slow_w_i(slw), .slow_inv_i(inv),
    .tim_o(tim), .blk_o(blk), .slow_o(slow), .ind_o(ind));

  always #4 clk = ~clk;

  function automatic int cyc(int ns);
    return (ns * MHZ + 999) / 1000;
  endfunction
  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // reference model: end cycle of each output
  int n = 0;
  int tim_end = 0, blk_end = 0, dead_end = 0, slow_end = 0, ind_end = 0;

  always @(posedge clk) begin
    int b, d, s;
    n = n + 1;
    if (!rst_n) begin
      tim_end = 0; blk_end = 0; dead_end = 0; slow_end = 0; ind_end = 0;
    end else if (trig && n >= dead_end && (!gated || gate)) begin
      b = cyc(clampi(int'(blk_ns), 10, 1000));
      d = (b > cyc(20)) ? b : cyc(20);
      s = cyc(clampi(int'(slw) * 10, 500, 2500));
      tim_end  = n + ((cyc(5) < 1) ? 1 : cyc(5));
      blk_end  = n + b;
      dead_end = n + d;
      slow_end = n + s;
      ind_end  = n + IND_C;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("tim0 R2", tim[0], n < tim_end);
      chk("tim1 R2", tim[1], n < tim_end);
      chk("blk R3", blk, n < blk_end);
      chk("slow R6 R7", slow, (n < slow_end) ^ inv);
      chk("ind R10", ind, n < ind_end);
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask
  task automatic fire();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask
  task automatic hold(int k);
    @(negedge clk); trig = 1'b1;
    step(k);
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R11 reset";
    trig = 1'b1;
    step(5);
    trig = 1'b0;
    rst_n = 1'b1;
    step(3);

    tag = "R1 R2 R3 single";
    fire(); step(350);

    tag = "R4 held trigger";
    hold(40); step(350);

    tag = "R5 R3 low clamp";
    blk_ns = 10'd5;
    hold(20); step(350);
    tag = "R3 high clamp";
    blk_ns = 10'd1023;
    fire(); step(150);
    blk_ns = 10'd100;

    tag = "R6 slow clamp high";
    slw = 8'd255;
    fire(); step(350);
    tag = "R6 slow clamp low";
    slw = 8'd10;
    fire(); step(100);
    tag = "R6 slow restart";
    slw = 8'd50;
    fire(); step(30); fire(); step(350);

    tag = "R7 inverted";
    inv = 1'b1;
    fire(); step(350);
    inv = 1'b0;
    step(5);

    tag = "R8 gate low";
    gated = 1'b1; gate = 1'b0;
    fire(); step(50);
    tag = "R8 gate drop mid set";
    gate = 1'b1;
    fire();
    gate = 1'b0;
    step(350);

    tag = "R9 ungated";
    gated = 1'b0; gate = 1'b0;
    fire(); step(350);

    tag = "R10 indicator hold";
    for (int i = 0; i < 4; i++) begin
      fire(); step(100);
    end
    step(300);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule